// File: doc/BRIEF.md
# GPIO Function Crossbar with Input Readback

This block joins a set of internal peripheral signals to a bank of general-purpose I/O lines. Every connection is chosen at the receiving end. Each GPIO line has two selectors: one picks the value the line drives, and the other picks the line's output enable. Each can choose any peripheral output or a fixed 0 or 1. Each peripheral input has its own selector, which can choose any GPIO input line or a fixed 0 or 1. Because of this, one peripheral output can fan out to several lines, and one GPIO input can feed several peripherals.

The GPIO inputs also pass through a two-flop synchronizer. The synchronized values are readable as 32-bit words, and they feed a level-sensitive interrupt for each line. Configuration uses a single-cycle register port. Writes take effect on the clock edge. Reads are combinational from the current register contents.

After reset, the CPU debug port is already usable. TDO drives line 0 with its enable tied high, and TCK, TDI, TMS and TRSTN take their values from lines 1, 2, 3 and 4. All other routes start at constant 0.

Top module: `gpio_fxbar`

## Requirements
- R1: Each line's `gpio_out` follows its output selector. Selector value 0 gives 0, value 1 gives 1, and value 2+k gives `periph_out[k]`. The change is combinational.
- R2: Each line's `gpio_oe` follows its own enable selector, which is separate from the output selector and uses the same encoding over `periph_out`.
- R3: Each `periph_in[j]` follows its selector. Value 0 gives 0, value 1 gives 1, and value 2+k gives the unsynchronized `gpio_in[k]`. The change is combinational.
- R4: A selector value of 2+k, where k is at or past the number of available sources, yields 0.
- R5: While reset is high and after it is released, the selectors hold these values. Output selector of line 0 = 2 (peripheral output 0, debug TDO). Enable selector of line 0 = 1. Input selectors of peripheral inputs 0..3 (TCK, TDI, TMS, TRSTN) = 3, 4, 5, 6, which are GPIO lines 1..4. Every other selector = 0. Enables, polarities and status are all 0.
- R6: Address 0xC0 reads the synchronized inputs of lines 0..31, with line n in bit n. Address 0xC1 reads lines 32..63. Each value reaches readback two clock edges after it appears on `gpio_in`. Writes to these two addresses change nothing.
- R7: Output selectors sit at address i (0x00+i), enable selectors at 0x40+i, and peripheral input selectors at 0x80+j. A write stores the low 7 bits of the data. A read returns the stored value, zero-extended.
- R8: Interrupt enable words sit at 0xC2/0xC3 and polarity words at 0xC4/0xC5, with line n in bit n of the lower word. A line's condition is true when it is enabled and its synchronized input equals its polarity bit (1 = active high). A true condition sets the line's status bit on the next edge. `irq` is the OR of all status bits.
- R9: Status words at 0xC6/0xC7 read the status bits. Writing 1 to a bit clears it. If the line's condition is still true at the same edge, setting takes priority.
- R10: Addresses 0xA0..0xBF and 0xC8..0xFF read as 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register word address, used for writes and reads |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| periph_out | input | 32 | Internal peripheral outputs |
| periph_in | output | 32 | Internal peripheral inputs, each routed from a GPIO line or a constant |
| gpio_in | input | 64 | GPIO line input values |
| gpio_out | output | 64 | GPIO line output values |
| gpio_oe | output | 64 | GPIO line output enables |
| irq | output | 1 | OR of all interrupt status bits |

## Verification
A behavioural model runs alongside the design and is compared on every clock. The bench first runs under the reset routing with random inputs, which shows whether the debug lines are wired to the right lines and whether every other route reads 0. It then programs routes that mix constants, distinct sources per line, and reversed input routing. Those patterns expose swapped or shared selectors between outputs and enables, as well as off-by-one source indexing. Out-of-range selector values, and writes to read-only and unmapped addresses, are used to separate true decode from aliasing. Inputs held steady against enabled polarities show whether a line's condition, when still true, keeps its status bit set through a clear. Inputs that are then released show whether the clear takes effect.

// File: rtl/gfx_pkg.sv
package gfx_pkg;

    localparam int ADDR_W    = 8;
    localparam int DATA_W    = 32;
    localparam int OUT_BASE  = 'h00;
    localparam int OE_BASE   = 'h40;
    localparam int IN_BASE   = 'h80;
    localparam int WORD_BASE = 'hC0;

    // debug port routing present at reset
    localparam int DBG_TDO_SRC   = 0;   // peripheral output index of TDO
    localparam int DBG_TDO_LINE  = 0;
    localparam int DBG_TCK_DST   = 0;   // peripheral input indices
    localparam int DBG_TDI_DST   = 1;
    localparam int DBG_TMS_DST   = 2;
    localparam int DBG_TRSTN_DST = 3;
    localparam int DBG_TCK_LINE  = 1;

    typedef enum logic [2:0] {
        KIND_NONE,
        KIND_OUT,
        KIND_OE,
        KIND_IN,
        KIND_WORD
    } reg_kind_e;

    typedef enum logic [1:0] {
        BANK_DIN,
        BANK_EN,
        BANK_POL,
        BANK_STS
    } word_bank_e;

    typedef struct packed {
        reg_kind_e  kind;
        word_bank_e bank;
        logic [5:0] idx;
    } reg_dec_t;

    function automatic int sel_bits(int nsrc_a, int nsrc_b);
        int widest;
        widest = (nsrc_a > nsrc_b) ? nsrc_a : nsrc_b;
        return $clog2(widest + 2);
    endfunction

    function automatic int default_out_sel(int line);
        return (line == DBG_TDO_LINE) ? (2 + DBG_TDO_SRC) : 0;
    endfunction

    function automatic int default_oe_sel(int line);
        return (line == DBG_TDO_LINE) ? 1 : 0;
    endfunction

    function automatic int default_in_sel(int dst);
        int r;
        case (dst)
            DBG_TCK_DST:   r = 2 + DBG_TCK_LINE;
            DBG_TDI_DST:   r = 2 + DBG_TCK_LINE + 1;
            DBG_TMS_DST:   r = 2 + DBG_TCK_LINE + 2;
            DBG_TRSTN_DST: r = 2 + DBG_TCK_LINE + 3;
            default:       r = 0;
        endcase
        return r;
    endfunction

    function automatic reg_dec_t decode_addr(logic [ADDR_W-1:0] a, int ngpio, int npi, int nw);
        reg_dec_t d;
        int ai;
        int off;
        ai     = int'(a);
        d.kind = KIND_NONE;
        d.bank = BANK_DIN;
        d.idx  = a[5:0];
        if (ai < OE_BASE) begin
            if (ai - OUT_BASE < ngpio) d.kind = KIND_OUT;
        end else if (ai < IN_BASE) begin
            if (ai - OE_BASE < ngpio) d.kind = KIND_OE;
        end else if (ai < WORD_BASE) begin
            if (ai - IN_BASE < npi) d.kind = KIND_IN;
        end else begin
            off = ai - WORD_BASE;
            if (off < 4 * nw) begin
                d.kind = KIND_WORD;
                d.bank = word_bank_e'(2'(off / nw));
                d.idx  = 6'(off % nw);
            end
        end
        return d;
    endfunction

endpackage

// File: rtl/gfx_select_bank.sv
module gfx_select_bank #(
    parameter int NDST = 64,
    parameter int NSRC = 32,
    parameter int SELW = 7
) (
    input  logic [NDST-1:0][SELW-1:0] sel,
    input  logic [NSRC-1:0]           src,
    output logic [NDST-1:0]           dst
);

    for (genvar d = 0; d < NDST; d++) begin : g_dst
        always_comb begin
            dst[d] = 1'b0;
            if (int'(sel[d]) == 1) begin
                dst[d] = 1'b1;
            end else begin
                for (int k = 0; k < NSRC; k++) begin
                    if (int'(sel[d]) == k + 2) dst[d] = src[k];
                end
            end
        end
    end

endmodule

// File: rtl/gfx_cfg_regs.sv
module gfx_cfg_regs
    import gfx_pkg::*;
#(
    parameter int NGPIO = 64,
    parameter int NPI   = 32,
    parameter int SELW  = 7,
    parameter int NW    = 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        reg_we,
    input  logic [ADDR_W-1:0]           reg_addr,
    input  logic [DATA_W-1:0]           reg_wdata,
    output logic [DATA_W-1:0]           reg_rdata,
    input  logic [NGPIO-1:0]            din_sync,
    input  logic [NGPIO-1:0]            status,
    output logic [NGPIO-1:0][SELW-1:0]  out_sel,
    output logic [NGPIO-1:0][SELW-1:0]  oe_sel,
    output logic [NPI-1:0][SELW-1:0]    in_sel,
    output logic [NGPIO-1:0]            irq_en,
    output logic [NGPIO-1:0]            irq_pol,
    output logic [NGPIO-1:0]            sts_clr
);

    reg_dec_t dec;
    assign dec = decode_addr(reg_addr, NGPIO, NPI, NW);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NGPIO; i++) begin
                out_sel[i] <= SELW'(default_out_sel(i));
                oe_sel[i]  <= SELW'(default_oe_sel(i));
            end
            for (int j = 0; j < NPI; j++) in_sel[j] <= SELW'(default_in_sel(j));
            irq_en  <= '0;
            irq_pol <= '0;
        end else if (reg_we) begin
            case (dec.kind)
                KIND_OUT: for (int i = 0; i < NGPIO; i++)
                              if (dec.idx == 6'(i)) out_sel[i] <= reg_wdata[SELW-1:0];
                KIND_OE:  for (int i = 0; i < NGPIO; i++)
                              if (dec.idx == 6'(i)) oe_sel[i] <= reg_wdata[SELW-1:0];
                KIND_IN:  for (int j = 0; j < NPI; j++)
                              if (dec.idx == 6'(j)) in_sel[j] <= reg_wdata[SELW-1:0];
                KIND_WORD: for (int w = 0; w < NW; w++) begin
                              if (dec.idx == 6'(w) && dec.bank == BANK_EN)
                                  irq_en[w*DATA_W +: DATA_W] <= reg_wdata;
                              if (dec.idx == 6'(w) && dec.bank == BANK_POL)
                                  irq_pol[w*DATA_W +: DATA_W] <= reg_wdata;
                          end
                default: ;
            endcase
        end
    end

    // write-one-to-clear mask for the status words
    always_comb begin
        sts_clr = '0;
        for (int w = 0; w < NW; w++) begin
            if (reg_we && dec.kind == KIND_WORD && dec.bank == BANK_STS && dec.idx == 6'(w))
                sts_clr[w*DATA_W +: DATA_W] = reg_wdata;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (dec.kind)
            KIND_OUT: for (int i = 0; i < NGPIO; i++)
                          if (dec.idx == 6'(i)) reg_rdata = DATA_W'(out_sel[i]);
            KIND_OE:  for (int i = 0; i < NGPIO; i++)
                          if (dec.idx == 6'(i)) reg_rdata = DATA_W'(oe_sel[i]);
            KIND_IN:  for (int j = 0; j < NPI; j++)
                          if (dec.idx == 6'(j)) reg_rdata = DATA_W'(in_sel[j]);
            KIND_WORD: for (int w = 0; w < NW; w++) begin
                          if (dec.idx == 6'(w)) begin
                              case (dec.bank)
                                  BANK_DIN: reg_rdata = din_sync[w*DATA_W +: DATA_W];
                                  BANK_EN:  reg_rdata = irq_en[w*DATA_W +: DATA_W];
                                  BANK_POL: reg_rdata = irq_pol[w*DATA_W +: DATA_W];
                                  default:  reg_rdata = status[w*DATA_W +: DATA_W];
                              endcase
                          end
                      end
            default: ;
        endcase
    end

    // R7: a selector write lands in the addressed register on the next edge
    assert_sel_write_R7: assert property (@(posedge clk) disable iff (rst)
        (reg_we && int'(reg_addr) == OUT_BASE) |=> (out_sel[0] == $past(reg_wdata[SELW-1:0])));

    // R6: data-in words are read-only
    assert_din_readonly_R6: assert property (@(posedge clk) disable iff (rst)
        (reg_we && int'(reg_addr) >= WORD_BASE && int'(reg_addr) < WORD_BASE + NW)
            |=> ($stable(irq_en) && $stable(irq_pol) && $stable(out_sel)));

endmodule

// File: rtl/gfx_in_sync_irq.sv
module gfx_in_sync_irq #(
    parameter int NGPIO = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NGPIO-1:0] gpio_in,
    input  logic [NGPIO-1:0] irq_en,
    input  logic [NGPIO-1:0] irq_pol,
    input  logic [NGPIO-1:0] sts_clr,
    output logic [NGPIO-1:0] din_sync,
    output logic [NGPIO-1:0] status,
    output logic             irq
);

    logic [NGPIO-1:0] meta_q;
    logic [NGPIO-1:0] cond;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q   <= '0;
            din_sync <= '0;
        end else begin
            meta_q   <= gpio_in;
            din_sync <= meta_q;
        end
    end

    assign cond = irq_en & ~(din_sync ^ irq_pol);

    always_ff @(posedge clk) begin
        if (rst) status <= '0;
        else     status <= (status & ~sts_clr) | cond;
    end

    assign irq = |status;

    // cycles since reset, saturating, used only by the checks below
    logic [1:0] age_q;
    always_ff @(posedge clk) begin
        if (rst)              age_q <= '0;
        else if (age_q != 2'd2) age_q <= age_q + 2'd1;
    end

    assert_sync_depth_R6: assert property (@(posedge clk) disable iff (rst)
        (age_q == 2'd2) |-> (din_sync == $past(gpio_in, 2)));

    assert_w1c_clears_R9: assert property (@(posedge clk) disable iff (rst)
        (age_q != 2'd0) |-> ((status & $past(sts_clr & ~cond)) == '0));

    assert_irq_cause_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(|cond));

    assert_set_wins_R9: assert property (@(posedge clk) disable iff (rst)
        (age_q != 2'd0) |-> ((status & $past(cond)) == $past(cond)));

endmodule

// File: rtl/gpio_fxbar.sv
module gpio_fxbar
    import gfx_pkg::*;
#(
    parameter int NGPIO = 64,
    parameter int NPO   = 32,
    parameter int NPI   = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [NPO-1:0]    periph_out,
    output logic [NPI-1:0]    periph_in,
    input  logic [NGPIO-1:0]  gpio_in,
    output logic [NGPIO-1:0]  gpio_out,
    output logic [NGPIO-1:0]  gpio_oe,
    output logic              irq
);

    localparam int SELW = sel_bits(NPO, NGPIO);
    localparam int NW   = NGPIO / DATA_W;

    logic [NGPIO-1:0][SELW-1:0] out_sel;
    logic [NGPIO-1:0][SELW-1:0] oe_sel;
    logic [NPI-1:0][SELW-1:0]   in_sel;
    logic [NGPIO-1:0]           irq_en;
    logic [NGPIO-1:0]           irq_pol;
    logic [NGPIO-1:0]           sts_clr;
    logic [NGPIO-1:0]           din_sync;
    logic [NGPIO-1:0]           status;

    gfx_cfg_regs #(.NGPIO(NGPIO), .NPI(NPI), .SELW(SELW), .NW(NW)) u_regs (
        .clk(clk), .rst(rst),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .din_sync(din_sync), .status(status),
        .out_sel(out_sel), .oe_sel(oe_sel), .in_sel(in_sel),
        .irq_en(irq_en), .irq_pol(irq_pol), .sts_clr(sts_clr)
    );

    gfx_select_bank #(.NDST(NGPIO), .NSRC(NPO), .SELW(SELW)) u_out_bank (
        .sel(out_sel), .src(periph_out), .dst(gpio_out)
    );

    gfx_select_bank #(.NDST(NGPIO), .NSRC(NPO), .SELW(SELW)) u_oe_bank (
        .sel(oe_sel), .src(periph_out), .dst(gpio_oe)
    );

    gfx_select_bank #(.NDST(NPI), .NSRC(NGPIO), .SELW(SELW)) u_in_bank (
        .sel(in_sel), .src(gpio_in), .dst(periph_in)
    );

    gfx_in_sync_irq #(.NGPIO(NGPIO)) u_sync_irq (
        .clk(clk), .rst(rst),
        .gpio_in(gpio_in), .irq_en(irq_en), .irq_pol(irq_pol), .sts_clr(sts_clr),
        .din_sync(din_sync), .status(status), .irq(irq)
    );

    for (genvar i = 0; i < NGPIO; i++) begin : g_oor_chk
        assert_oor_out_R4: assert property (@(posedge clk) disable iff (rst)
            (int'(out_sel[i]) >= NPO + 2) |-> !gpio_out[i]);
        assert_oor_oe_R4: assert property (@(posedge clk) disable iff (rst)
            (int'(oe_sel[i]) >= NPO + 2) |-> !gpio_oe[i]);
    end

    for (genvar j = 0; j < NPI; j++) begin : g_oor_in_chk
        assert_oor_in_R4: assert property (@(posedge clk) disable iff (rst)
            (int'(in_sel[j]) >= NGPIO + 2) |-> !periph_in[j]);
    end

endmodule

// File: tb/gpio_fxbar_test.sv
`timescale 1ns/1ps
module gpio_fxbar_test;

    localparam int NG  = 64;
    localparam int NPO = 32;
    localparam int NPI = 32;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [NPO-1:0] periph_out = '0;
    logic [NPI-1:0] periph_in;
    logic [NG-1:0]  gpio_in = '0;
    logic [NG-1:0]  gpio_out;
    logic [NG-1:0]  gpio_oe;
    logic           irq;

    always #2.5 clk = ~clk;   // 200 MHz

    gpio_fxbar uut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .periph_out(periph_out), .periph_in(periph_in),
        .gpio_in(gpio_in), .gpio_out(gpio_out), .gpio_oe(gpio_oe), .irq(irq)
    );

    int nchecks = 0;
    int nerrors = 0;
    bit done = 0;
    string focus = "R5";

    // reference model state
    int m_out[NG];
    int m_oe[NG];
    int m_in[NPI];
    logic [NG-1:0] m_s1, m_s2, m_en, m_pol, m_st;

    function automatic int pick(int sel, logic [63:0] v, int n);
        if (sel == 1) return 1;
        if (sel >= 2 && sel - 2 < n) return int'(v[sel-2]);
        return 0;
    endfunction

    function automatic logic [31:0] model_read(int a, output string tag);
        tag = "R10";
        if (a < 'h40)                        begin tag = "R7"; return 32'(m_out[a]); end
        if (a < 'h80)                        begin tag = "R7"; return 32'(m_oe[a-'h40]); end
        if (a < 'hC0) begin
            if (a - 'h80 < NPI)              begin tag = "R7"; return 32'(m_in[a-'h80]); end
            return '0;
        end
        case (a)
            'hC0: begin tag = "R6"; return m_s2[31:0];  end
            'hC1: begin tag = "R6"; return m_s2[63:32]; end
            'hC2: begin tag = "R8"; return m_en[31:0];  end
            'hC3: begin tag = "R8"; return m_en[63:32]; end
            'hC4: begin tag = "R8"; return m_pol[31:0]; end
            'hC5: begin tag = "R8"; return m_pol[63:32]; end
            'hC6: begin tag = "R9"; return m_st[31:0];  end
            'hC7: begin tag = "R9"; return m_st[63:32]; end
            default: return '0;
        endcase
    endfunction

    task automatic check(input logic [63:0] act, input logic [63:0] exp, input string req, input string what);
        nchecks++;
        if (act !== exp) begin
            nerrors++;
            $display("FAIL %s %s (phase %s): actual %h expected %h", req, what, focus, act, exp);
        end
    endtask

    task automatic compare();
        logic [63:0] e_out, e_oe, e_in;
        string rtag;
        logic [31:0] e_rd;
        e_out = '0; e_oe = '0; e_in = '0;
        for (int i = 0; i < NG; i++) begin
            e_out[i] = pick(m_out[i], 64'(periph_out), NPO)[0];
            e_oe[i]  = pick(m_oe[i], 64'(periph_out), NPO)[0];
        end
        for (int j = 0; j < NPI; j++) e_in[j] = pick(m_in[j], gpio_in, NG)[0];
        check(gpio_out, e_out, "R1", "gpio_out");
        check(gpio_oe, e_oe, "R2", "gpio_oe");
        check(64'(periph_in), e_in, "R3", "periph_in");
        e_rd = model_read(int'(reg_addr), rtag);
        check(64'(reg_rdata), 64'(e_rd), rtag, $sformatf("reg_rdata @%h", reg_addr));
        check(64'(irq), 64'(|m_st), "R8", "irq");
    endtask

    task automatic set_defaults();
        for (int i = 0; i < NG; i++) begin m_out[i] = 0; m_oe[i] = 0; end
        for (int j = 0; j < NPI; j++) m_in[j] = 0;
        m_out[0] = 2; m_oe[0] = 1;
        m_in[0] = 3; m_in[1] = 4; m_in[2] = 5; m_in[3] = 6;
        m_s1 = '0; m_s2 = '0; m_en = '0; m_pol = '0; m_st = '0;
    endtask

    // compare, then advance the model across one edge
    task automatic tick(input bit do_check = 1);
        logic [NG-1:0] clr, cond, n_s1, n_st;
        int a;
        #1;
        if (do_check) compare();
        a = int'(reg_addr);
        clr = '0;
        if (reg_we && a == 'hC6) clr[31:0]  = reg_wdata;
        if (reg_we && a == 'hC7) clr[63:32] = reg_wdata;
        cond = m_en & ~(m_s2 ^ m_pol);
        n_s1 = gpio_in;
        n_st = (m_st & ~clr) | cond;
        @(posedge clk);
        if (rst) begin
            set_defaults();
        end else begin
            if (reg_we) begin
                if (a < 'h40) m_out[a] = int'(reg_wdata[6:0]);
                else if (a < 'h80) m_oe[a-'h40] = int'(reg_wdata[6:0]);
                else if (a < 'h80 + NPI) m_in[a-'h80] = int'(reg_wdata[6:0]);
                else if (a == 'hC2) m_en[31:0]   = reg_wdata;
                else if (a == 'hC3) m_en[63:32]  = reg_wdata;
                else if (a == 'hC4) m_pol[31:0]  = reg_wdata;
                else if (a == 'hC5) m_pol[63:32] = reg_wdata;
            end
            m_s2 = m_s1;
            m_s1 = n_s1;
            m_st = n_st;
        end
        #1;
    endtask

    task automatic randomize_inputs();
        periph_out = $urandom;
        gpio_in    = {$urandom, $urandom};
    endtask

    task automatic write_reg(input int a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = 8'(a); reg_wdata = d;
        tick();
        reg_we = 1'b0;
    endtask

    initial begin
        set_defaults();
        // reset phase: R5 defaults visible while rst is high
        tick(0);
        for (int k = 0; k < 4; k++) begin
            randomize_inputs();
            reg_addr = 8'(k == 0 ? 'h00 : (k == 1 ? 'h40 : 'h80 + k));
            tick();
        end
        rst = 1'b0;
        // R5: debug routing after release
        for (int k = 0; k < 8; k++) begin
            randomize_inputs();
            reg_addr = 8'(k < 4 ? 'h80 + k : 'h01 + k);
            tick();
        end

        // R1, R2, R7: mixed output and enable routes
        focus = "R1";
        for (int i = 0; i < NG; i++) write_reg(i, 32'(i % 3 == 0 ? 0 : (i % 3 == 1 ? 1 : 2 + (i % NPO))));
        focus = "R2";
        for (int i = 0; i < NG; i++) write_reg('h40 + i, 32'(2 + ((i * 7 + 3) % NPO)) | 32'hFFFF_FF00);
        focus = "R3";
        for (int j = 0; j < NPI; j++) write_reg('h80 + j, 32'(2 + (NG - 1 - j)));
        focus = "R7";
        for (int k = 0; k < 40; k++) begin
            randomize_inputs();
            if (k == 5)  periph_out = '1;
            if (k == 6)  periph_out = 32'h5555_5555;
            if (k == 7)  gpio_in = 64'h1 << (k * 5);
            reg_addr = 8'((k * 13) % 'hA0);
            tick();
        end

        // R4: out-of-range selectors read as 0
        focus = "R4";
        write_reg('h05, 32'(NPO + 2));
        write_reg('h06, 32'h7F);
        write_reg('h45, 32'(NPO + 2));
        write_reg('h81, 32'(NG + 2));
        write_reg('h82, 32'h7F);
        for (int k = 0; k < 10; k++) begin
            periph_out = '1; gpio_in = '1;
            reg_addr = 8'(k % 2 == 0 ? 'h05 : 'h82);
            tick();
        end

        // R6: data-in readback with sync delay; writes ignored
        focus = "R6";
        for (int k = 0; k < 24; k++) begin
            randomize_inputs();
            reg_addr = 8'('hC0 + (k % 2));
            tick();
        end
        write_reg('hC0, 32'hFFFF_FFFF);
        write_reg('hC1, 32'hFFFF_FFFF);
        for (int k = 0; k < 4; k++) begin reg_addr = 8'('hC0 + (k % 2)); tick(); end

        // R8, R9: level interrupt, polarity, write-one-to-clear
        focus = "R8";
        gpio_in = 64'h0000_0001_0000_000F;
        write_reg('hC4, 32'h0000_00F3);
        write_reg('hC5, 32'h0000_0000);
        write_reg('hC2, 32'h0000_00FF);
        write_reg('hC3, 32'h0000_0003);
        for (int k = 0; k < 6; k++) begin reg_addr = 8'('hC6 + (k % 2)); tick(); end
        focus = "R9";
        write_reg('hC6, 32'hFFFF_FFFF);   // held lines stay set
        reg_addr = 8'hC6; tick(); tick();
        gpio_in = 64'h0000_0001_0000_00F0;  // line 0..3 conditions false now for pol bits 0,1
        write_reg('hC2, 32'h0);
        write_reg('hC3, 32'h0);
        for (int k = 0; k < 3; k++) begin reg_addr = 8'hC6; tick(); end
        write_reg('hC6, 32'h0000_000C);
        write_reg('hC7, 32'hFFFF_FFFF);
        for (int k = 0; k < 3; k++) begin reg_addr = 8'('hC6 + (k % 2)); tick(); end
        write_reg('hC6, 32'hFFFF_FFFF);
        reg_addr = 8'hC6; tick(); tick();

        // R10: unmapped addresses
        focus = "R10";
        write_reg('hA0, 32'h7F);
        write_reg('hC8, 32'hFFFF_FFFF);
        write_reg('hFF, 32'hFFFF_FFFF);
        for (int k = 0; k < 6; k++) begin
            randomize_inputs();
            reg_addr = 8'(k == 0 ? 'hA0 : (k == 1 ? 'hC8 : (k == 2 ? 'hFF : 'hBF + k)));
            tick();
        end

        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrors);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1;
            nchecks++;
            nerrors++;
            $display("FAIL watchdog expired (phase %s): actual running expected finished", focus);
            $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrors);
            $finish;
        end
    end

endmodule